// File: doc/BRIEF.md
# E1 Per-Timeslot Payload Controller

This block sits in the transmit path of one E1 framer and changes the outgoing payload one timeslot at a time. Each cycle it may receive one byte with its timeslot number (0 to 31), the four signaling bits for that timeslot, a byte from an external pattern generator and a byte from the payload loopback path. It looks up the timeslot's entry in a 32-entry configuration table and picks one action for that byte. The result leaves one clock cycle later, tagged with the same timeslot number.

The per-byte decision is an enumerated action. Only one action is chosen for each byte, in a fixed priority order: `ACT_TAP` (copy the byte to the test tap and send it unchanged), `ACT_LOOP` (send the loopback byte), `ACT_MW` (send the milliwatt sequence), `ACT_PAT` (send the generator byte), `ACT_IDLE` (send the timeslot's idle code), `ACT_INV` (invert selected bits) and `ACT_PASS` (send the input unchanged). A separate phase register steps through the eight milliwatt entries. It moves to the next entry after timeslot 31, takes entry 0 after reset and wraps from 7 to 0. Signaling bits are replaced independently of the byte action.

Top module: `e1_ts_payload_ctrl`

## Requirements
- R1: While `glb_en` is 0, every byte and signaling nibble leaves unchanged, and `tap_valid` stays 0.
- R2: Table entry k occupies `ts_cfg_flat[18k+17:18k]`, with bit 0 = test, bit 1 = loop, bits 4:2 = select code {subs,ds0,ds1}, bits 12:5 = idle code, bit 13 = signaling source, bits 17:14 = ABCD. With code 000 and no other action, the byte passes unchanged.
- R3: Select code 100 or 101 replaces the byte with that timeslot's idle code.
- R4: Select code 001 XORs the byte with 0xAA (odd bits 1,3,5,7), 010 XORs it with 0x55 (even bits) and 011 XORs it with 0xFF.
- R5: Select code 111 sends the A-law milliwatt sequence 34,21,21,34,B4,A1,A1,B4 and code 110 sends 1E,0B,0B,1E,9E,8B,8B,9E. The entry index is 0 after reset and advances by one after each byte of timeslot 31, wrapping from 7 to 0.
- R6: The priority from highest to lowest is tap, loopback, milliwatt, pattern insert, idle, inversion.
- R7: With `pat_on`=1 and `pat_dir`=0, the generator byte replaces every timeslot when `unf_gen`=1. When `unf_gen`=0 it replaces only the timeslots whose test bit is 1.
- R8: With `pat_on`=1 and `pat_dir`=1, a timeslot is tapped when `unf_det`=1 or its test bit is 1. A tapped timeslot raises `tap_valid`, copies the input byte to `tap_byte`, and sends the byte unchanged.
- R9: When `glb_en`, `cas_en` and the timeslot's signaling-source bit are all 1, `out_sig` carries the entry's ABCD bits. Otherwise it carries `sig_in`.
- R10: Outputs are registered with one cycle of latency: `out_valid` follows `ts_valid` and `out_ts` equals the input timeslot. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable for the per-timeslot table |
| cas_en | input | 1 | Channel-associated signaling in use |
| pat_on | input | 1 | Pattern path attached to this framer |
| pat_dir | input | 1 | 1 = tap outgoing data, 0 = insert pattern |
| unf_det | input | 1 | Tap every timeslot, ignoring test bits |
| unf_gen | input | 1 | Insert into every timeslot, ignoring test bits |
| ts_cfg_flat | input | 576 | 32 table entries of 18 bits each |
| ts_valid | input | 1 | Input byte present |
| ts_idx | input | 5 | Timeslot number of the input byte |
| tx_byte | input | 8 | Transmit payload byte |
| sig_in | input | 4 | Input ABCD signaling |
| pat_byte | input | 8 | Pattern generator byte |
| lpbk_byte | input | 8 | Payload loopback byte |
| out_valid | output | 1 | Output byte present |
| out_ts | output | 5 | Timeslot number of the output byte |
| out_byte | output | 8 | Processed payload byte |
| out_sig | output | 4 | Processed ABCD signaling |
| tap_valid | output | 1 | Tap byte present |
| tap_byte | output | 8 | Byte sent to the pattern detector |

## Verification
Some properties are checked on every cycle: the one-cycle alignment of valid and timeslot number, full bypass while the global enable is low, signaling pass-through while signaling is off, agreement between the tap byte and the outgoing byte, and unframed insertion of the pattern whenever no higher-priority action applies. Other behaviour appears only in the bench scenarios. These are the value of each idle code and inversion mask, the priority chain resolved by each table entry, framed selection by test bit, and the milliwatt sequence in both laws, which needs ten full frames to show its order and its wrap.

// File: rtl/e1pc_pkg.sv
package e1pc_pkg;
    localparam int CFG_W  = 18;
    localparam int MW_LEN = 8;

    typedef struct packed {
        logic [3:0] abcd;
        logic       sigsrc;
        logic [7:0] idle;
        logic [2:0] sel;    // {subs, ds0, ds1}
        logic       loop;
        logic       test;
    } ts_cfg_t;

    typedef enum logic [2:0] {
        ACT_PASS, ACT_TAP, ACT_LOOP, ACT_MW, ACT_PAT, ACT_IDLE, ACT_INV
    } act_e;

    function automatic logic [7:0] mw_lookup(input logic alt, input logic [2:0] ph);
        logic [7:0] b;
        case (ph)
            3'd0, 3'd3: b = alt ? 8'h1E : 8'h34;
            3'd1, 3'd2: b = alt ? 8'h0B : 8'h21;
            3'd4, 3'd7: b = alt ? 8'h9E : 8'hB4;
            default:    b = alt ? 8'h8B : 8'hA1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/e1pc_mw_seq.sv
module e1pc_mw_seq #(
    parameter int NTS    = 32,
    parameter int PH_LEN = e1pc_pkg::MW_LEN,
    localparam int TSW   = $clog2(NTS),
    localparam int PHW   = $clog2(PH_LEN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ts_valid,
    input  logic [TSW-1:0] ts_idx,
    output logic [PHW-1:0] phase
);
    localparam logic [TSW-1:0] LAST_TS = TSW'(NTS - 1);
    localparam logic [PHW-1:0] LAST_PH = PHW'(PH_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (ts_valid && ts_idx == LAST_TS) begin
            phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/e1pc_action_dec.sv
module e1pc_action_dec
    import e1pc_pkg::*;
(
    input  logic    glb_en,
    input  logic    pat_on,
    input  logic    pat_dir,
    input  logic    unf_det,
    input  logic    unf_gen,
    input  logic    test,
    input  logic    loop,
    input  logic [2:0] sel,
    output act_e    act
);
    logic tap_hit, gen_hit;

    always_comb begin
        tap_hit = pat_on && pat_dir && (unf_det || test);
        gen_hit = pat_on && !pat_dir && (unf_gen || test);
        if (!glb_en)                 act = ACT_PASS;
        else if (tap_hit)            act = ACT_TAP;
        else if (loop)               act = ACT_LOOP;
        else if (sel[2:1] == 2'b11)  act = ACT_MW;
        else if (gen_hit)            act = ACT_PAT;
        else if (sel[2:1] == 2'b10)  act = ACT_IDLE;
        else if (sel != 3'b000)      act = ACT_INV;
        else                         act = ACT_PASS;
    end
endmodule

// File: rtl/e1pc_byte_mux.sv
module e1pc_byte_mux
    import e1pc_pkg::*;
#(
    parameter int NTS = 32,
    localparam int TSW = $clog2(NTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ts_valid,
    input  logic [TSW-1:0] ts_idx,
    input  act_e           act,
    input  logic [1:0]     inv_sel,
    input  logic [7:0]     idle,
    input  logic           sig_sub,
    input  logic [3:0]     abcd,
    input  logic [7:0]     tx_byte,
    input  logic [7:0]     pat_byte,
    input  logic [7:0]     lpbk_byte,
    input  logic [7:0]     mw_byte,
    input  logic [3:0]     sig_in,
    output logic           out_valid,
    output logic [TSW-1:0] out_ts,
    output logic [7:0]     out_byte,
    output logic [3:0]     out_sig,
    output logic           tap_valid,
    output logic [7:0]     tap_byte
);
    logic [7:0] nxt_byte, inv_mask;

    always_comb begin
        unique case (inv_sel)
            2'b01:   inv_mask = 8'hAA;
            2'b10:   inv_mask = 8'h55;
            2'b11:   inv_mask = 8'hFF;
            default: inv_mask = 8'h00;
        endcase
        unique case (act)
            ACT_TAP:  nxt_byte = tx_byte;
            ACT_LOOP: nxt_byte = lpbk_byte;
            ACT_MW:   nxt_byte = mw_byte;
            ACT_PAT:  nxt_byte = pat_byte;
            ACT_IDLE: nxt_byte = idle;
            ACT_INV:  nxt_byte = tx_byte ^ inv_mask;
            default:  nxt_byte = tx_byte;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ts    <= '0;
            out_byte  <= '0;
            out_sig   <= '0;
            tap_valid <= 1'b0;
            tap_byte  <= '0;
        end else begin
            out_valid <= ts_valid;
            tap_valid <= ts_valid && (act == ACT_TAP);
            if (ts_valid) begin
                out_ts   <= ts_idx;
                out_byte <= nxt_byte;
                out_sig  <= sig_sub ? abcd : sig_in;
                tap_byte <= (act == ACT_TAP) ? tx_byte : 8'h00;
            end
        end
    end
endmodule

// File: rtl/e1_ts_payload_ctrl.sv
module e1_ts_payload_ctrl
    import e1pc_pkg::*;
#(
    parameter int NTS = 32,
    localparam int TSW = $clog2(NTS),
    localparam int PHW = $clog2(MW_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glb_en,
    input  logic                 cas_en,
    input  logic                 pat_on,
    input  logic                 pat_dir,
    input  logic                 unf_det,
    input  logic                 unf_gen,
    input  logic [NTS*CFG_W-1:0] ts_cfg_flat,
    input  logic                 ts_valid,
    input  logic [TSW-1:0]       ts_idx,
    input  logic [7:0]           tx_byte,
    input  logic [3:0]           sig_in,
    input  logic [7:0]           pat_byte,
    input  logic [7:0]           lpbk_byte,
    output logic                 out_valid,
    output logic [TSW-1:0]       out_ts,
    output logic [7:0]           out_byte,
    output logic [3:0]           out_sig,
    output logic                 tap_valid,
    output logic [7:0]           tap_byte
);
    ts_cfg_t        cfg_cur;
    act_e           act;
    logic [PHW-1:0] mw_phase;
    logic [7:0]     mw_byte;
    logic           sig_sub;

    assign cfg_cur = ts_cfg_flat[ts_idx*CFG_W +: CFG_W];
    assign mw_byte = mw_lookup(!cfg_cur.sel[0], mw_phase);
    assign sig_sub = glb_en && cas_en && cfg_cur.sigsrc;

    e1pc_mw_seq #(.NTS(NTS), .PH_LEN(MW_LEN)) u_mw (
        .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_idx(ts_idx),
        .phase(mw_phase)
    );

    e1pc_action_dec u_dec (
        .glb_en(glb_en), .pat_on(pat_on), .pat_dir(pat_dir),
        .unf_det(unf_det), .unf_gen(unf_gen), .test(cfg_cur.test),
        .loop(cfg_cur.loop), .sel(cfg_cur.sel), .act(act)
    );

    e1pc_byte_mux #(.NTS(NTS)) u_mux (
        .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_idx(ts_idx),
        .act(act), .inv_sel(cfg_cur.sel[1:0]), .idle(cfg_cur.idle),
        .sig_sub(sig_sub), .abcd(cfg_cur.abcd), .tx_byte(tx_byte),
        .pat_byte(pat_byte), .lpbk_byte(lpbk_byte), .mw_byte(mw_byte),
        .sig_in(sig_in), .out_valid(out_valid), .out_ts(out_ts),
        .out_byte(out_byte), .out_sig(out_sig), .tap_valid(tap_valid),
        .tap_byte(tap_byte)
    );
endmodule

// File: rtl/e1pc_checker.sv
module e1pc_checker
    import e1pc_pkg::*;
#(
    parameter int NTS = 32,
    localparam int TSW = $clog2(NTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 glb_en,
    input logic                 cas_en,
    input logic                 pat_on,
    input logic                 pat_dir,
    input logic                 unf_gen,
    input logic [NTS*CFG_W-1:0] ts_cfg_flat,
    input logic                 ts_valid,
    input logic [TSW-1:0]       ts_idx,
    input logic [7:0]           tx_byte,
    input logic [3:0]           sig_in,
    input logic [7:0]           pat_byte,
    input logic                 out_valid,
    input logic [TSW-1:0]       out_ts,
    input logic [7:0]           out_byte,
    input logic [3:0]           out_sig,
    input logic                 tap_valid,
    input logic [7:0]           tap_byte
);
    ts_cfg_t ent;
    assign ent = ts_cfg_flat[ts_idx*CFG_W +: CFG_W];

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |=> (out_valid && out_ts == $past(ts_idx)));

    p_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_valid |=> !out_valid);

    p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !glb_en) |=> (out_byte == $past(tx_byte) &&
                                   out_sig == $past(sig_in) && !tap_valid));

    p_sig_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !cas_en) |=> (out_sig == $past(sig_in)));

    p_tap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tap_valid |-> (out_valid && out_byte == tap_byte));

    p_unframed_gen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && glb_en && pat_on && !pat_dir && unf_gen && !ent.loop &&
         ent.sel[2:1] != 2'b11) |=> (out_byte == $past(pat_byte)));
endmodule

bind e1_ts_payload_ctrl e1pc_checker #(.NTS(NTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cas_en(cas_en),
    .pat_on(pat_on), .pat_dir(pat_dir), .unf_gen(unf_gen),
    .ts_cfg_flat(ts_cfg_flat), .ts_valid(ts_valid), .ts_idx(ts_idx),
    .tx_byte(tx_byte), .sig_in(sig_in), .pat_byte(pat_byte),
    .out_valid(out_valid), .out_ts(out_ts), .out_byte(out_byte),
    .out_sig(out_sig), .tap_valid(tap_valid), .tap_byte(tap_byte)
);

// File: tb/tb_e1_ts_payload_ctrl.sv
module tb_e1_ts_payload_ctrl;
    localparam int EW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic glb_en = 0, cas_en = 0, pat_on = 0, pat_dir = 0, unf_det = 0, unf_gen = 0;
    logic [32*EW-1:0] cfg = '0;
    logic ts_valid = 0;
    logic [4:0] ts_idx = '0;
    logic [7:0] tx_byte = '0, pat_byte = 8'hC3, lpbk_byte = 8'h5A;
    logic [3:0] sig_in = '0;
    logic out_valid, tap_valid;
    logic [4:0] out_ts;
    logic [7:0] out_byte, tap_byte;
    logic [3:0] out_sig;

    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    e1_ts_payload_ctrl dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cas_en(cas_en),
        .pat_on(pat_on), .pat_dir(pat_dir), .unf_det(unf_det), .unf_gen(unf_gen),
        .ts_cfg_flat(cfg), .ts_valid(ts_valid), .ts_idx(ts_idx),
        .tx_byte(tx_byte), .sig_in(sig_in), .pat_byte(pat_byte),
        .lpbk_byte(lpbk_byte), .out_valid(out_valid), .out_ts(out_ts),
        .out_byte(out_byte), .out_sig(out_sig), .tap_valid(tap_valid),
        .tap_byte(tap_byte)
    );

    typedef struct packed {
        logic [3:0] req;
        logic glb, pon, pdir, unfd, unfg, cas;
        logic [4:0] ts;
        logic test, loop;
        logic [2:0] sel;
        logic [7:0] idle;
        logic ssrc;
        logic [3:0] abcd;
        logic [7:0] tx;
        logic [3:0] sig;
        logic [7:0] eb;
        logic [3:0] es;
        logic etap;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        // req glb pon pdir unfd unfg cas ts  test loop sel     idle   ss abcd  tx     sig   exp    esig  tap
        '{4'd1, 0,0,0,0,0,0, 5'd2,  0,0, 3'b101, 8'h77, 0,4'h0, 8'h0F, 4'h3, 8'h0F, 4'h3, 0}, // R1
        '{4'd3, 1,0,0,0,0,0, 5'd3,  0,0, 3'b101, 8'h77, 0,4'h0, 8'h0F, 4'h3, 8'h77, 4'h3, 0}, // R3
        '{4'd3, 1,0,0,0,0,0, 5'd4,  0,0, 3'b100, 8'h11, 0,4'h0, 8'h0F, 4'h3, 8'h11, 4'h3, 0}, // R3
        '{4'd4, 1,0,0,0,0,0, 5'd7,  0,0, 3'b001, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'hA5, 4'h3, 0}, // R4
        '{4'd4, 1,0,0,0,0,0, 5'd8,  0,0, 3'b010, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'h5A, 4'h3, 0}, // R4
        '{4'd4, 1,0,0,0,0,0, 5'd9,  0,0, 3'b011, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'hF0, 4'h3, 0}, // R4
        '{4'd5, 1,0,0,0,0,0, 5'd10, 0,0, 3'b111, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'h34, 4'h3, 0}, // R5
        '{4'd5, 1,0,0,0,0,0, 5'd11, 0,0, 3'b110, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'h1E, 4'h3, 0}, // R5
        '{4'd6, 1,0,0,0,0,0, 5'd12, 0,1, 3'b111, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'h5A, 4'h3, 0}, // R6 loop over mw
        '{4'd6, 1,1,0,0,0,0, 5'd13, 1,0, 3'b101, 8'h77, 0,4'h0, 8'h0F, 4'h3, 8'hC3, 4'h3, 0}, // R6 pattern over idle
        '{4'd2, 1,1,0,0,0,0, 5'd14, 0,0, 3'b000, 8'h77, 0,4'h0, 8'h0F, 4'h3, 8'h0F, 4'h3, 0}, // R2 / R7 framed, not marked
        '{4'd7, 1,1,0,0,1,0, 5'd15, 0,0, 3'b000, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'hC3, 4'h3, 0}, // R7 unframed
        '{4'd6, 1,1,0,0,0,0, 5'd16, 1,0, 3'b111, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'h34, 4'h3, 0}, // R6 mw over pattern
        '{4'd8, 1,1,1,0,0,0, 5'd17, 1,1, 3'b101, 8'h77, 0,4'h0, 8'h0F, 4'h3, 8'h0F, 4'h3, 1}, // R8 framed tap
        '{4'd8, 1,1,1,1,0,0, 5'd18, 0,0, 3'b011, 8'h00, 0,4'h0, 8'h66, 4'h3, 8'h66, 4'h3, 1}, // R8 unframed tap
        '{4'd8, 1,1,1,0,0,0, 5'd19, 0,0, 3'b011, 8'h00, 0,4'h0, 8'h0F, 4'h3, 8'hF0, 4'h3, 0}, // R8 not tapped
        '{4'd9, 1,0,0,0,0,1, 5'd20, 0,0, 3'b000, 8'h00, 1,4'h9, 8'h0F, 4'h3, 8'h0F, 4'h9, 0}, // R9
        '{4'd9, 1,0,0,0,0,0, 5'd21, 0,0, 3'b000, 8'h00, 1,4'h9, 8'h0F, 4'h3, 8'h0F, 4'h3, 0}, // R9 cas off
        '{4'd1, 0,0,0,0,0,1, 5'd22, 0,0, 3'b000, 8'h00, 1,4'h9, 8'h0F, 4'h3, 8'h0F, 4'h3, 0}  // R1 sig
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_entry(input logic [4:0] ts, input logic [EW-1:0] e);
        cfg[ts*EW +: EW] = e;
    endtask

    task automatic send(input logic [4:0] ts, input logic [7:0] tx, input logic [3:0] sg);
        @(negedge clk);
        ts_idx = ts; tx_byte = tx; sig_in = sg; ts_valid = 1'b1;
        @(negedge clk);
        ts_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [7:0] mw_a [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
    logic [7:0] mw_u [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};

    initial begin
        repeat (2) @(negedge clk);
        // R10 reset state
        chk("R10 reset valid", {31'd0, out_valid}, 0);
        chk("R10 reset byte", {24'd0, out_byte}, 0);
        chk("R10 reset sig", {28'd0, out_sig}, 0);
        chk("R10 reset tap", {31'd0, tap_valid}, 0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = TBL[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            glb_en = v.glb; pat_on = v.pon; pat_dir = v.pdir;
            unf_det = v.unfd; unf_gen = v.unfg; cas_en = v.cas;
            set_entry(v.ts, {v.abcd, v.ssrc, v.idle, v.sel, v.loop, v.test});
            send(v.ts, v.tx, v.sig);
            chk({tag, " byte"}, {24'd0, out_byte}, {24'd0, v.eb});
            chk({tag, " sig"}, {28'd0, out_sig}, {28'd0, v.es});
            chk({tag, " tap"}, {31'd0, tap_valid}, {31'd0, v.etap});
            if (v.etap) chk({tag, " tap byte"}, {24'd0, tap_byte}, {24'd0, v.tx});
            chk({tag, " ts (R10)"}, {27'd0, out_ts}, {27'd0, v.ts});
        end

        // R10: valid drops one cycle after input goes idle
        @(negedge clk);
        chk("R10 idle valid", {31'd0, out_valid}, 0);

        // R5: milliwatt sequences across frames, with wrap
        glb_en = 1; pat_on = 0; cas_en = 0; unf_gen = 0; unf_det = 0;
        cfg = '0;
        set_entry(5'd5, {4'h0, 1'b0, 8'h00, 3'b111, 1'b0, 1'b0});
        set_entry(5'd6, {4'h0, 1'b0, 8'h00, 3'b110, 1'b0, 1'b0});
        do_reset();
        for (int f = 0; f < 10; f++) begin
            for (int t = 0; t < 32; t++) begin
                send(5'(t), 8'h00, 4'h0);
                if (t == 5) chk($sformatf("R5 A-law frame %0d", f), {24'd0, out_byte}, {24'd0, mw_a[f % 8]});
                if (t == 6) chk($sformatf("R5 alt frame %0d", f), {24'd0, out_byte}, {24'd0, mw_u[f % 8]});
            end
        end

        // R2: code 000 passes unchanged with everything else off
        send(5'd31, 8'h3C, 4'h0);
        chk("R2 pass", {24'd0, out_byte}, 32'h3C);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule